// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer

The block holds six independent down-counters behind a small register bus with address, write data, write strobe and combinational read data. Each channel has a control word, an interval (reload) value and a live count. A channel picks one of four tick-enable inputs, divides it by a power of two, and decrements its count on each divided tick. When the count expires, the channel raises its status bit. It then reloads on the next divided tick (periodic mode) or stops and clears its own enable bit (one-shot mode).

A shared interrupt-enable register and a shared write-one-to-clear status register form one interrupt line per channel. The clock sources are single-cycle enable pulses in the block's own clock domain. A source input that is never pulsed leaves its channels frozen.

Top module: `pit_array`

## Requirements
- R1: After reset, irq is 0, the enable and status registers read 0, every interval and count reads 0, and every control register reads 0x04 (source 1, divide by 1, stopped).
- R2: Register map. Interrupt enable is at 0x00 in bits [5:0] and status is at 0x04. Channel i (0..5) uses base (i+1)*0x10, with control at +0x0, interval at +0x4 and count at +0x8. Any other offset reads 0, and writes to it change nothing.
- R3: irq[i] is status[i] AND enable[i], and it follows a change to either register from the next clock edge.
- R4: A status write clears each bit written as 1 and leaves bits written as 0 unchanged. If an expiry and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: Control bit 0 is run enable, bit 1 is reload, bits [3:2] select the tick source, bits [6:4] are the prescale exponent N, and bit 7 set selects one-shot. A control write with bit 1 set copies the interval into the count at that edge.
- R6: A running channel steps its count once per 2^N pulses of its selected source. A control write restarts the prescaler phase and drops any pulse in the same cycle.
- R7: A step from count 1 to 0 is an expiry and sets the channel's status bit.
- R8: In periodic mode, a step at count 0 reloads the interval. The enable bit stays set and expiries repeat every interval+1 steps.
- R9: In one-shot mode, an expiry clears control bit 0, which shows on readback, and the count holds at 0.
- R10: A stopped channel never changes its count, and neither do pulses on sources it has not selected.
- R11: Writes to a count register are ignored, and a read returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_tick | input | 4 | Tick-enable pulses of the four clock sources |
| irq | output | 6 | Per-channel interrupt lines |

## Verification
The collision that matters is a software clear of a status bit landing in the same cycle as that channel's expiry. The bench provokes it by setting a channel with interval 1 and prescale 1 on a source it pulses itself. After a reload, it drives the status clear and the final source pulse in the same cycle. The bit must read back as set afterwards, and a later clear with no expiry must leave it at 0. A second collision, a control write together with a source pulse, is judged by the count not stepping on that edge.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int NUM_SRC = 4;

    // Register offsets inside the window
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_INTV = 4'h4;
    localparam logic [3:0] OFS_CNT  = 4'h8;
    localparam int         ADR_IEN  = 'h00;
    localparam int         ADR_STAT = 'h04;

    // Control word, bit 7 down to bit 0
    typedef struct packed {
        logic       one_shot;  // 7
        logic [2:0] pre_exp;   // 6:4
        logic [1:0] src;       // 3:2
        logic       reload;    // 1
        logic       en;        // 0
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{one_shot: 1'b0, pre_exp: 3'd0,
                                     src: 2'd1, reload: 1'b0, en: 1'b0};

    // Terminal phase of the prescaler for a divide of 2^e
    function automatic logic [6:0] pre_mask(input logic [2:0] e);
        return 7'h7F >> (3'd7 - e);
    endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler
    import pit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       run,
    input  logic       tick,
    input  logic [2:0] exp_sel,
    output logic       step
);
    logic [6:0] phase;

    assign step = run && tick && (phase == pre_mask(exp_sel));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
        end else if (run && tick) begin
            phase <= step ? 7'd0 : phase + 7'd1;
        end
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctrl_we,
    input  logic               intv_we,
    input  logic [CW-1:0]      wdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output ctrl_t              ctrl_q,
    output logic [CW-1:0]      intv_q,
    output logic [CW-1:0]      cnt_q,
    output logic               fire
);
    ctrl_t ctrl_new;
    logic  sel_tick;
    logic  step;
    logic  at_zero;

    assign ctrl_new = ctrl_t'(wdata[7:0]);
    assign sel_tick = src_tick[ctrl_q.src];
    assign at_zero  = (cnt_q == '0);

    pit_prescaler u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (ctrl_we),
        .run     (ctrl_q.en),
        .tick    (sel_tick),
        .exp_sel (ctrl_q.pre_exp),
        .step    (step)
    );

    // Expiry: stepping 1 -> 0, or a one-shot stepped while already at 0
    assign fire = step && !ctrl_we &&
                  ((cnt_q == CW'(1)) || (at_zero && ctrl_q.one_shot));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            intv_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (intv_we) begin
                intv_q <= wdata;
            end
            if (ctrl_we) begin
                ctrl_q <= ctrl_new;
                if (ctrl_new.reload) begin
                    cnt_q <= intv_q;
                end
            end else if (step) begin
                if (at_zero) begin
                    cnt_q <= ctrl_q.one_shot ? '0 : intv_q;
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
                if (fire && ctrl_q.one_shot) begin
                    ctrl_q.en <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pit_array.sv
module pit_array
    import pit_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CW     = 32,
    parameter int AW     = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      bus_addr,
    input  logic [CW-1:0]      bus_wdata,
    input  logic               bus_we,
    output logic [CW-1:0]      bus_rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic [NUM_CH-1:0]  irq
);
    localparam int BW = AW - 4;

    logic [NUM_CH-1:0] ien_q, stat_q;
    logic [NUM_CH-1:0] fire_vec, ch_en_vec, ch_os_vec;
    logic [NUM_CH-1:0] clr_mask;
    logic              ien_we, stat_we;
    ctrl_t             ctrl_a [NUM_CH];
    logic [CW-1:0]     intv_a [NUM_CH];
    logic [CW-1:0]     cnt_a  [NUM_CH];

    assign ien_we   = bus_we && (bus_addr == AW'(ADR_IEN));
    assign stat_we  = bus_we && (bus_addr == AW'(ADR_STAT));
    assign clr_mask = stat_we ? bus_wdata[NUM_CH-1:0] : '0;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            logic hit;
            assign hit = (bus_addr[AW-1:4] == BW'(g + 1));

            pit_channel #(.CW(CW)) u_ch (
                .clk      (clk),
                .rst      (rst),
                .ctrl_we  (bus_we && hit && (bus_addr[3:0] == OFS_CTRL)),
                .intv_we  (bus_we && hit && (bus_addr[3:0] == OFS_INTV)),
                .wdata    (bus_wdata),
                .src_tick (src_tick),
                .ctrl_q   (ctrl_a[g]),
                .intv_q   (intv_a[g]),
                .cnt_q    (cnt_a[g]),
                .fire     (fire_vec[g])
            );

            assign ch_en_vec[g] = ctrl_a[g].en;
            assign ch_os_vec[g] = ctrl_a[g].one_shot;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= '0;
            stat_q <= '0;
        end else begin
            if (ien_we) begin
                ien_q <= bus_wdata[NUM_CH-1:0];
            end
            // Expiry wins over a clear in the same cycle
            stat_q <= (stat_q & ~clr_mask) | fire_vec;
        end
    end

    assign irq = stat_q & ien_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADR_IEN)) begin
            bus_rdata = {{(CW-NUM_CH){1'b0}}, ien_q};
        end else if (bus_addr == AW'(ADR_STAT)) begin
            bus_rdata = {{(CW-NUM_CH){1'b0}}, stat_q};
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr[AW-1:4] == BW'(i + 1)) begin
                case (bus_addr[3:0])
                    OFS_CTRL: bus_rdata = {{(CW-8){1'b0}}, ctrl_a[i]};
                    OFS_INTV: bus_rdata = intv_a[i];
                    OFS_CNT:  bus_rdata = cnt_a[i];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pit_array_chk.sv
module pit_array_chk #(
    parameter int NUM_CH = 6,
    parameter int CW     = 32,
    parameter int AW     = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [AW-1:0]     bus_addr,
    input logic [CW-1:0]     bus_wdata,
    input logic              bus_we,
    input logic [NUM_CH-1:0] irq,
    input logic [NUM_CH-1:0] stat_q,
    input logic [NUM_CH-1:0] fire_vec,
    input logic [NUM_CH-1:0] ch_en_vec,
    input logic [NUM_CH-1:0] ch_os_vec
);
    // R1: reset leaves every line low
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (irq == '0));

    // R3: clearing all enables silences every line
    p_irq_masked_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == '0 && bus_wdata[NUM_CH-1:0] == '0) |=> (irq == '0));

    // R4: bits written as 1 clear unless an expiry hits them
    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == AW'(4)) |=>
        ((stat_q & $past(bus_wdata[NUM_CH-1:0] & ~fire_vec)) == '0));

    // R4: an expiry always lands in status
    p_expiry_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (fire_vec != '0) |=> ((stat_q & $past(fire_vec)) == $past(fire_vec)));

    // R9: one-shot expiry drops the enable bit
    p_oneshot_stop_r9: assert property (@(posedge clk) disable iff (rst)
        ((fire_vec & ch_os_vec) != '0) |=>
        ((ch_en_vec & $past(fire_vec & ch_os_vec)) == '0));

    // R8: periodic expiry keeps the channel running
    p_periodic_keep_r8: assert property (@(posedge clk) disable iff (rst)
        ((fire_vec & ~ch_os_vec) != '0) |=>
        ((ch_en_vec & $past(fire_vec & ~ch_os_vec)) == $past(fire_vec & ~ch_os_vec)));
endmodule

bind pit_array pit_array_chk #(.NUM_CH(NUM_CH), .CW(CW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .irq       (irq),
    .stat_q    (stat_q),
    .fire_vec  (fire_vec),
    .ch_en_vec (ch_en_vec),
    .ch_os_vec (ch_os_vec)
);

// File: tb/pit_array_tb.sv
module pit_array_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick = '0;
    logic [5:0]  irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pit_array u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .src_tick  (src_tick),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp_v);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [9:0] a, input logic [31:0] exp_v);
        @(negedge clk);
        bus_addr = a;
        #1 chk(tag, bus_rdata, exp_v);
    endtask

    task automatic tk(input logic [3:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            src_tick = m;
            @(negedge clk);
            src_tick = '0;
        end
    endtask

    task automatic t_reset;
        #1 chk("R1 irq", 32'(irq), 0);
        rd_chk("R1 ien", 10'h000, 0);
        rd_chk("R1 stat", 10'h004, 0);
        rd_chk("R1 ctrl0", 10'h010, 32'h04);
        rd_chk("R1 ctrl5", 10'h060, 32'h04);
        rd_chk("R1 intv5", 10'h064, 0);
        rd_chk("R1 cnt3", 10'h048, 0);
    endtask

    task automatic t_map;
        wr(10'h034, 32'h55);
        rd_chk("R2 intv2", 10'h034, 32'h55);
        wr(10'h064, 32'h64);
        rd_chk("R2 intv5", 10'h064, 32'h64);
        wr(10'h3F0, 32'hFFFF);
        rd_chk("R2 unmapped", 10'h3F0, 0);
        wr(10'h074, 32'h77);
        rd_chk("R2 beyond ch", 10'h074, 0);
        rd_chk("R2 gap", 10'h00C, 0);
        wr(10'h018, 32'h99);
        rd_chk("R11 cnt write ignored", 10'h018, 0);
    endtask

    task automatic t_oneshot;
        wr(10'h014, 32'd3);
        wr(10'h010, 32'h83);           // en, reload, src0, N0, one-shot
        rd_chk("R5 reload", 10'h018, 32'd3);
        tk(4'b0001, 2);
        rd_chk("R11 live cnt", 10'h018, 32'd1);
        rd_chk("R7 not yet", 10'h004, 0);
        tk(4'b0001, 1);
        rd_chk("R7 expiry cnt", 10'h018, 0);
        rd_chk("R7 status", 10'h004, 32'h1);
        rd_chk("R9 en cleared", 10'h010, 32'h82);
        #1 chk("R3 masked", 32'(irq), 0);
        wr(10'h000, 32'h1);
        #1 chk("R3 irq on", 32'(irq), 32'h1);
        tk(4'b0001, 2);
        rd_chk("R9 holds 0", 10'h018, 0);
        wr(10'h004, 32'h0);
        rd_chk("R4 zero keeps", 10'h004, 32'h1);
        wr(10'h004, 32'h1);
        rd_chk("R4 cleared", 10'h004, 0);
        #1 chk("R3 irq off", 32'(irq), 0);
    endtask

    task automatic t_prescale;
        wr(10'h024, 32'd10);
        wr(10'h020, 32'h2B);           // en, reload, src2, N2, periodic
        tk(4'b0100, 3);
        rd_chk("R6 three ticks", 10'h028, 32'd10);
        tk(4'b0100, 1);
        rd_chk("R6 fourth tick", 10'h028, 32'd9);
        tk(4'b0100, 3);
        rd_chk("R6 partial", 10'h028, 32'd9);
        tk(4'b1011, 5);
        rd_chk("R10 other srcs", 10'h028, 32'd9);
        tk(4'b0100, 1);
        rd_chk("R6 step", 10'h028, 32'd8);
    endtask

    task automatic t_periodic;
        wr(10'h034, 32'd2);
        wr(10'h030, 32'h07);           // en, reload, src1, N0, periodic
        tk(4'b0010, 2);
        rd_chk("R8 expire", 10'h004, 32'h4);
        wr(10'h004, 32'h4);
        tk(4'b0010, 1);
        rd_chk("R8 reload", 10'h038, 32'd2);
        rd_chk("R8 no expiry at reload", 10'h004, 0);
        rd_chk("R8 en kept", 10'h030, 32'h07);
        tk(4'b0010, 2);
        rd_chk("R8 second expiry", 10'h004, 32'h4);
        wr(10'h004, 32'h4);
    endtask

    task automatic t_stopped;
        wr(10'h030, 32'h06);           // reload, not running
        rd_chk("R5 reload stopped", 10'h038, 32'd2);
        tk(4'b0010, 3);
        rd_chk("R10 stopped", 10'h038, 32'd2);
    endtask

    task automatic t_collide;
        wr(10'h044, 32'd1);
        wr(10'h040, 32'h0F);           // en, reload, src3, N0, periodic
        tk(4'b1000, 1);
        rd_chk("R7 ch3 expiry", 10'h004, 32'h8);
        wr(10'h004, 32'h8);
        rd_chk("R4 ch3 clear", 10'h004, 0);
        tk(4'b1000, 1);                 // reload to 1
        @(negedge clk);
        bus_addr = 10'h004; bus_wdata = 32'h8; bus_we = 1'b1; src_tick = 4'b1000;
        @(negedge clk);
        bus_we = 1'b0; src_tick = '0;
        rd_chk("R4 expiry wins", 10'h004, 32'h8);
        wr(10'h004, 32'h8);
        rd_chk("R4 clear after", 10'h004, 0);
    endtask

    task automatic t_phase;
        wr(10'h054, 32'd5);
        wr(10'h050, 32'h13);           // en, reload, src0, N1
        tk(4'b0001, 1);
        rd_chk("R6 half", 10'h058, 32'd5);
        wr(10'h050, 32'h11);
        tk(4'b0001, 1);
        rd_chk("R6 phase restart", 10'h058, 32'd5);
        tk(4'b0001, 1);
        rd_chk("R6 after restart", 10'h058, 32'd4);
        @(negedge clk);                  // control write with a pulse: no step
        bus_addr = 10'h050; bus_wdata = 32'h11; bus_we = 1'b1; src_tick = 4'b0001;
        @(negedge clk);
        bus_we = 1'b0; src_tick = '0;
        rd_chk("R6 pulse dropped", 10'h058, 32'd4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_map;
        t_oneshot;
        t_prescale;
        t_periodic;
        t_stopped;
        t_collide;
        t_phase;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule